// File: doc/BRIEF.md
# Byte-Serial AES-128 Round-Key Expander

This block turns a 128-bit cipher key into the full AES-128 schedule of eleven 16-byte round keys, one byte per clock. After a one-cycle start pulse the key is taken in over sixteen clocks, one byte per clock, and written to the first sixteen locations of an internal round-key store. The block then derives the remaining 160 bytes one per clock, so an expansion occupies exactly 176 busy cycles.

It has no four-word register file. Each new byte is formed from two sources. The first is the byte sixteen places earlier, which is read back from the store one clock ahead, at the write address minus fifteen. The second is either a four-byte temporary word or a four-byte history of recently written bytes. The temporary word is built during the last four clocks of every round. In those clocks the final word is byte-rotated, substituted through the S-box, and one of its bytes takes the round constant.

A second, independent read port lets a cipher datapath fetch any stored round-key byte by address at any time. Its data appears one clock after the address.

Top module: `aes_kx_serial`

## Requirements
- R1: After reset, `busy_o` and `done_o` are both 0, and they are never 1 in the same cycle.
- R2: A `start_i` pulse sets `busy_o` on the next clock. `busy_o` then stays high for exactly 176 clocks, after which `done_o` rises in the same cycle that `busy_o` falls.
- R3: During busy cycles 0 to 15, the byte on `key_i` is stored at address equal to the cycle index. Address 0 holds the first key byte, in standard AES byte order. `key_i` is ignored in all other cycles.
- R4: For each round r from 1 to 10 and byte j from 0 to 3, the byte at address 16r+j equals byte (16(r-1)+j) XOR S(byte at 16r-4+((j+1) mod 4)). For j=0 the round constant of round r is also XORed in. In other words, the last word is rotated by one byte, substituted, and the constant lands on the byte taken from position 1.
- R5: The round constant starts at 0x01 and is doubled in GF(2^8) each round, reducing by 0x1B on overflow. This gives 01,02,04,08,10,20,40,80,1B,36 for rounds 1 to 10.
- R6: For every address a from 16 to 175 with (a mod 16) of 4 or more, byte a equals byte (a-16) XOR byte (a-4).
- R7: `done_o` holds until the next `start_i`. A `start_i` during an expansion abandons it and begins a new one at address 0 with the newly supplied key.
- R8: `rk_data_o` shows the stored byte at the `rk_addr_i` value of the previous clock.
- R9: For the standard test key 2b7e151628aed2a6abf7158809cf4f3c, bytes 16 to 19 are a0 fa fe 17 and bytes 160 to 175 are d014f9a8c9ee2589e13f0cc8b6630ca6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that starts an expansion |
| key_i | input | 8 | Key byte, sampled during busy cycles 0 to 15 |
| rk_addr_i | input | 8 | Round-key byte address for the cipher datapath |
| rk_data_o | output | 8 | Round-key byte, one clock after the address |
| busy_o | output | 1 | Expansion in progress |
| done_o | output | 1 | Full schedule is stored |

## Verification
The bench targets the round seams: bytes 0 to 3 of each round, which depend on the rotated, substituted word of the previous round. A wrong rotation order or a constant placed on the wrong byte corrupts only those four bytes, and the error then ripples through the rest of the schedule. The last round constants, 1B and 36, are checked on their own, since a doubling without reduction gives 00 and a wrong value from round 9 onwards. An off-by-one in the read-back address would mix in the wrong earlier byte from byte 16 onward. A restart in the middle of an expansion is also applied, to catch stale counters or a constant that is not reset.

// File: rtl/aes_kx_pkg.sv
package aes_kx_pkg;

  function automatic logic [7:0] gf_dbl(input logic [7:0] a);
    gf_dbl = {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_dbl(sh);
    end
    gf_mul = acc;
  endfunction

  // multiplicative inverse as x^254, zero maps to zero
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] sq;
    logic [7:0] r;
    sq = x;
    r  = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    gf_inv = r;
  endfunction

  function automatic logic [7:0] sub_byte(input logic [7:0] x);
    logic [7:0] b;
    b = gf_inv(x);
    sub_byte = b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
             ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

endpackage

// File: rtl/kx_ram.sv
module kx_ram #(
  parameter int DEPTH = 176,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [W-1:0]  ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [W-1:0]  rb_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (waddr < AW'(DEPTH))) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    ra_data <= (ra_addr < AW'(DEPTH)) ? mem[ra_addr] : '0;
    rb_data <= (rb_addr < AW'(DEPTH)) ? mem[rb_addr] : '0;
  end

  AST_WADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (waddr < AW'(DEPTH))); // R3
endmodule

// File: rtl/kx_rcon.sv
module kx_rcon
  import aes_kx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic       step_i,
  output logic [7:0] rcon_o
);
  logic [7:0] rcon_q, rcon_d;

  always_comb begin
    rcon_d = rcon_q;
    if (load_i)      rcon_d = 8'h01;
    else if (step_i) rcon_d = gf_dbl(rcon_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rcon_q <= 8'h01;
    else        rcon_q <= rcon_d;
  end

  assign rcon_o = rcon_q;

  AST_RCON_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rcon_q != 8'h00); // R5
  AST_RCON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> rcon_q == 8'h01); // R5
endmodule

// File: rtl/aes_kx_serial.sv
module aes_kx_serial
  import aes_kx_pkg::*;
#(
  parameter int KEY_BYTES = 16,
  parameter int ROUNDS    = 10,
  localparam int DEPTH    = KEY_BYTES * (ROUNDS + 1),
  localparam int AW       = $clog2(DEPTH),
  localparam int JW       = $clog2(KEY_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [7:0]    key_i,
  input  logic [AW-1:0] rk_addr_i,
  output logic [7:0]    rk_data_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW-1:0] BACK = AW'(KEY_BYTES - 1);

  logic          busy_q, busy_d, done_q, done_d;
  logic [AW-1:0] cnt_q, cnt_d;
  logic [7:0]    tw_q   [4];
  logic [7:0]    hist_q [4];
  logic [7:0]    back_byte, wbyte, sbyte, rcon;
  logic [JW-1:0] j;
  logic [1:0]    tslot;
  logic          in_key, tail;

  assign j      = cnt_q[JW-1:0];
  assign in_key = cnt_q < AW'(KEY_BYTES);
  assign tail   = j >= JW'(KEY_BYTES - 4);
  assign tslot  = j[1:0] - 2'd1;   // rotation: byte k lands in slot k-1

  // sequencer next state
  always_comb begin
    busy_d = busy_q;
    done_d = done_q;
    cnt_d  = cnt_q;
    if (start_i) begin
      busy_d = 1'b1;
      done_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  // byte former
  always_comb begin
    if (in_key)          wbyte = key_i;
    else if (j < JW'(4)) wbyte = back_byte ^ tw_q[j[1:0]];
    else                 wbyte = back_byte ^ hist_q[3];
  end

  assign sbyte = sub_byte(wbyte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        tw_q[i]   <= '0;
        hist_q[i] <= '0;
      end
    end else if (busy_q) begin
      hist_q[0] <= wbyte;
      for (int i = 1; i < 4; i++) hist_q[i] <= hist_q[i-1];
      if (tail) tw_q[tslot] <= sbyte ^ ((j[1:0] == 2'd1) ? rcon : 8'h00);
    end
  end

  kx_rcon u_rcon (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start_i),
    .step_i (busy_q && !start_i && (j == JW'(KEY_BYTES - 1))),
    .rcon_o (rcon)
  );

  kx_ram #(.DEPTH(DEPTH), .W(8)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (busy_q),
    .waddr   (cnt_q),
    .wdata   (wbyte),
    .ra_addr (cnt_q - BACK),
    .ra_data (back_byte),
    .rb_addr (rk_addr_i),
    .rb_data (rk_data_o)
  );

  assign busy_o = busy_q;
  assign done_o = done_q;

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q)); // R1
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_q && (cnt_q == '0) && !done_q); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !start_i && cnt_q != LAST) |=> busy_q && (cnt_q == $past(cnt_q) + 1'b1)); // R2
  AST_DONE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(busy_q) && ($past(cnt_q) == LAST)); // R2
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start_i) |=> done_q); // R7
endmodule

// File: tb/aes_kx_serial_tb.sv
module aes_kx_serial_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [7:0] key_i;
  logic [7:0] rk_addr_i;
  logic [7:0] rk_data_o;
  logic       busy_o, done_o;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  logic [7:0] exp_ks [176];
  logic [7:0] got    [176];
  logic [7:0] key    [16];

  always #5 clk = ~clk;

  aes_kx_serial u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .key_i(key_i),
    .rk_addr_i(rk_addr_i), .rk_data_o(rk_data_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  function automatic logic [7:0] m2(input logic [7:0] a);
    return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
  endfunction

  function automatic logic [7:0] mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0;
    logic [7:0] x = a;
    logic [7:0] y = b;
    while (y != 0) begin
      if (y[0]) p ^= x;
      x = m2(x);
      y = y >> 1;
    end
    return p;
  endfunction

  // inverse by search, then affine map
  function automatic logic [7:0] sbx(input logic [7:0] v);
    logic [7:0] inv = 0;
    logic [7:0] r;
    for (int y = 1; y < 256; y++) if (mul(v, 8'(y)) == 8'h01) inv = 8'(y);
    r = 8'h63;
    for (int k = 0; k < 5; k++) r ^= (inv << k) | (inv >> (8 - k));
    return r;
  endfunction

  function automatic logic [7:0] rc(input int r);
    logic [7:0] v = 8'h01;
    for (int i = 1; i < r; i++) v = m2(v);
    return v;
  endfunction

  task automatic build_ref();
    for (int i = 0; i < 16; i++) exp_ks[i] = key[i];
    for (int w = 4; w < 44; w++) begin
      logic [7:0] t [4];
      for (int b = 0; b < 4; b++) t[b] = exp_ks[4*(w-1)+b];
      if (w % 4 == 0) begin
        logic [7:0] s [4];
        for (int b = 0; b < 4; b++) s[b] = sbx(t[(b+1)%4]);
        s[0] ^= rc(w/4);
        t = s;
      end
      for (int b = 0; b < 4; b++) exp_ks[4*w+b] = exp_ks[4*(w-4)+b] ^ t[b];
    end
  endtask

  task automatic check(input string req, input int act, input int expv, input string what);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // after start: feed key over 16 cycles, junk on key_i afterwards
  task automatic feed(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      key_i = (c < 16) ? key[c] : 8'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic read_all();
    for (int a = 0; a < 176; a++) begin
      rk_addr_i = 8'(a);
      @(negedge clk);
      got[a] = rk_data_o;
    end
  endtask

  task automatic run_full(input string tag);
    pulse_start();
    check("R2", busy_o, 1, {tag, " busy after start"});
    feed(175);
    check("R2", busy_o, 1, {tag, " busy in cycle 175"});
    check("R2", done_o, 0, {tag, " no done before last byte"});
    feed(1);
    check("R2", busy_o, 0, {tag, " busy drops after 176"});
    check("R2", done_o, 1, {tag, " done after 176"});
    build_ref();
    read_all();
    check("R7", done_o, 1, {tag, " done held"});
  endtask

  task automatic compare_all(input string tag);
    int e3 = 0, e4 = 0, e6 = 0;
    for (int a = 0; a < 176; a++) begin
      if (got[a] !== exp_ks[a]) begin
        if (a < 16) e3++; else if (a % 16 < 4) e4++; else e6++;
        $display("FAIL %s byte %0d: actual=%0h expected=%0h",
                 (a < 16) ? "R3" : ((a % 16 < 4) ? "R4" : "R6"), a, got[a], exp_ks[a]);
      end
    end
    total += 3;
    bad += (e3 != 0) + (e4 != 0) + (e6 != 0);
    // R5: recover constant of each round from stored bytes
    for (int r = 1; r <= 10; r++)
      check("R5", got[16*r] ^ got[16*(r-1)] ^ sbx(got[16*r-3]), rc(r), {tag, " round constant"});
  endtask

  initial begin
    #(200000 * 10);
    if (!ended) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] fk;
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; start_i = 1'b0; key_i = 8'h00; rk_addr_i = 8'h00;
    #23;
    check("R1", busy_o, 0, "busy in reset");
    check("R1", done_o, 0, "done in reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", busy_o, 0, "busy after reset");
    check("R1", done_o, 0, "done after reset");

    // R9 standard vector
    fk = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    for (int i = 0; i < 16; i++) key[i] = fk[127-8*i -: 8];
    run_full("std");
    compare_all("std");
    check("R9", {got[16], got[17], got[18], got[19]}, 32'ha0fafe17, "round 1 word 0");
    for (int i = 0; i < 4; i++)
      check("R9", {got[160+4*i], got[161+4*i], got[162+4*i], got[163+4*i]},
            (128'hd014f9a8c9ee2589e13f0cc8b6630ca6 >> (96 - 32*i)) & 32'hffffffff, "last round key");

    // R8 read port latency: address change shows next cycle
    rk_addr_i = 8'd175; @(negedge clk);
    rk_addr_i = 8'd0;
    check("R8", rk_data_o, got[175], "data for previous address");
    @(negedge clk);
    check("R8", rk_data_o, got[0], "data after address change");

    // directed corners: all zero, all ones
    for (int i = 0; i < 16; i++) key[i] = 8'h00;
    run_full("zero"); compare_all("zero");
    for (int i = 0; i < 16; i++) key[i] = 8'hff;
    run_full("ones"); compare_all("ones");

    // random keys
    for (int n = 0; n < 5; n++) begin
      for (int i = 0; i < 16; i++) key[i] = 8'($urandom);
      run_full("rand"); compare_all("rand");
    end

    // R7 restart in the middle of an expansion with a new key
    for (int i = 0; i < 16; i++) key[i] = 8'($urandom);
    pulse_start();
    feed(60);
    for (int i = 0; i < 16; i++) key[i] = 8'($urandom);
    run_full("restart");
    compare_all("restart R7");

    ended = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule